// File: doc/BRIEF.md
# 8x8 Forward DCT Unit

This block computes the two-dimensional forward discrete cosine transform of an 8x8 tile of signed pixel samples. Samples arrive one per cycle on a push port and are placed in an input tile in row-major order. A start command launches the transform, which runs as a separable two-pass summation over a 17-bit signed table of cosines held in Q15 fixed point. Each coefficient is scaled by one quarter and by the normalisation factors of its two frequencies. It is then quantised by an arithmetic division by 64 and stored in an output tile.

While the transform runs the unit reports busy, and it ignores pushes, pops and further starts. A single-cycle done pulse marks the moment the output tile holds the new result. Coefficients are then read one per pop in row-major order of (u, v). The unit does one multiply-accumulate per cycle, so a transform takes a fixed 4160 cycles.

Top module: `dct8_top`

## Requirements
- R1: A push accepted while idle writes push_data into input entry 8*row+col at the write index, then advances the index by one, wrapping 63 to 0. A push while busy is ignored and leaves the write index unchanged.
- R2: A start while idle raises busy from the next cycle for exactly 4160 cycles. A start while busy is ignored.
- R3: done is high for exactly one cycle, the first cycle after busy falls. busy falls only at that moment.
- R4: Coefficient (u,v) uses the integer sum S = sum over x of (sum over y of D[x][y]*T(y,v)) * T(x,u), where T(p,f) is cos((2p+1)f*pi/16) times 32768 with the magnitude truncated: the magnitudes 32768, 32138, 30273, 27245, 23170, 18204, 12539, 6392, 0 belong to multiples 0..8 of pi/16.
- R5: The stored result is floor(S * Ku * Kv / 2^68), where Kf is 23170 for f=0 and 32768 otherwise. This covers the 1/4 scale, both Q15 factors and a quantising arithmetic shift right by 6. The result is a signed 16-bit value.
- R6: pop_data shows output entry 8*u+v at the read index. A pop while idle advances the read index, wrapping 63 to 0, and the index returns to 0 in the cycle done is high.
- R7: A pop while busy is ignored and does not move the read index.
- R8: A push in the same cycle as an accepted start is written first and takes part in that transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_valid | input | 1 | Write one sample into the input tile |
| push_data | input | PIX_W (8) | Signed pixel sample |
| start | input | 1 | Begin the transform |
| pop_req | input | 1 | Advance to the next output coefficient |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse: output tile valid |
| pop_data | output | OUT_W (16) | Signed coefficient at the read index |

## Verification
Two functions can land in the same cycle: loading the last sample of a tile and launching the transform. The bench provokes this by pushing 63 samples and then asserting push and start together on the 64th. The behavioural reference applies the push before it takes its snapshot for the transform, so any coefficient that misses the final sample is reported. Pops, pushes and starts that arrive during busy are also mixed in, and every cycle is compared against the reference.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  localparam int N      = 8;
  localparam int PIX_W  = 8;
  localparam int FRAC   = 15;
  localparam int COS_W  = FRAC + 2;
  localparam int OUT_W  = 16;
  localparam int QSHIFT = 6;
  localparam int C0_Q   = 23170;
  localparam int ONE_Q  = 32768;

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_SCALE} eng_st_t;

  // Q15 value of cos((2*pos+1)*freq*pi/16), magnitude truncated
  function automatic logic signed [COS_W-1:0] cos_q15(input logic [2:0] pos,
                                                      input logic [2:0] freq);
    logic [4:0] m;
    logic [4:0] fold;
    logic neg;
    logic signed [COS_W-1:0] mag;
    m = {1'b0, pos, 1'b1} * {2'b00, freq};
    if (m <= 5'd8) begin
      fold = m;           neg = 1'b0;
    end else if (m <= 5'd16) begin
      fold = 5'd16 - m;   neg = 1'b1;
    end else if (m <= 5'd24) begin
      fold = m - 5'd16;   neg = 1'b1;
    end else begin
      fold = 5'd0 - m;    neg = 1'b0;
    end
    case (fold)
      5'd0:    mag = 17'sd32768;
      5'd1:    mag = 17'sd32138;
      5'd2:    mag = 17'sd30273;
      5'd3:    mag = 17'sd27245;
      5'd4:    mag = 17'sd23170;
      5'd5:    mag = 17'sd18204;
      5'd6:    mag = 17'sd12539;
      5'd7:    mag = 17'sd6392;
      default: mag = 17'sd0;
    endcase
    return neg ? -mag : mag;
  endfunction
endpackage

// File: rtl/dct8_in_buf.sv
module dct8_in_buf
  import dct8_pkg::*;
#(
  parameter int W     = PIX_W,
  parameter int DEPTH = N * N,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic signed [W-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic signed [W-1:0] rd_data,
  output logic [AW-1:0]       wr_idx
);
  logic signed [W-1:0] mem [DEPTH];
  logic [AW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (wr_en) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx_q] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
  assign wr_idx  = idx_q;
endmodule

// File: rtl/dct8_out_buf.sv
module dct8_out_buf
  import dct8_pkg::*;
#(
  parameter int W     = OUT_W,
  parameter int DEPTH = N * N,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic signed [W-1:0] wr_data,
  input  logic                pop_en,
  input  logic                clr,
  output logic signed [W-1:0] rd_data,
  output logic [AW-1:0]       rd_idx
);
  logic signed [W-1:0] mem [DEPTH];
  logic [AW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr)         idx_d = '0;
    else if (pop_en) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[idx_q];
  assign rd_idx  = idx_q;
endmodule

// File: rtl/dct8_engine.sv
module dct8_engine
  import dct8_pkg::*;
#(
  parameter int PW  = PIX_W,
  parameter int OW  = OUT_W,
  parameter int QSH = QSHIFT,
  localparam int AW   = $clog2(N * N),
  localparam int S_W  = PW + COS_W + 3,
  localparam int P_W  = S_W + COS_W,
  localparam int ACC_W = P_W + 3,
  localparam int K_W  = 2 * FRAC + 2,
  localparam int SC_W = ACC_W + K_W,
  localparam int SH   = 4 * FRAC + 2 + QSH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_en,
  input  logic signed [PW-1:0] pix_data,
  output logic [AW-1:0]        pix_addr,
  output logic                 ob_we,
  output logic [AW-1:0]        ob_addr,
  output logic signed [OW-1:0] ob_data,
  output logic                 last_wr,
  output logic                 busy,
  output logic                 done
);
  eng_st_t st_q, st_d;
  logic [AW-1:0] coef_q, coef_d, term_q, term_d;
  logic signed [S_W-1:0]   s_q, s_d, pix_prod, s_full;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [P_W-1:0]   outer;
  logic signed [COS_W-1:0] cy, cx, kcu, kcv;
  logic signed [K_W-1:0]   kmul;
  logic signed [SC_W-1:0]  scaled;
  logic done_d, done_q;
  logic [2:0] x, y, u, v;

  assign {x, y} = term_q;
  assign {u, v} = coef_q;

  // first pass term and second pass weight
  assign cy       = cos_q15(y, v);
  assign cx       = cos_q15(x, u);
  assign pix_prod = pix_data * cy;
  assign s_full   = s_q + pix_prod;
  assign outer    = s_full * cx;

  // normalisation, quarter scale and quantising shift
  assign kcu    = (u == 3'd0) ? COS_W'(C0_Q) : COS_W'(ONE_Q);
  assign kcv    = (v == 3'd0) ? COS_W'(C0_Q) : COS_W'(ONE_Q);
  assign kmul   = kcu * kcv;
  assign scaled = acc_q * kmul;
  assign ob_data = OW'(scaled >>> SH);

  always_comb begin
    st_d   = st_q;
    coef_d = coef_q;
    term_d = term_q;
    s_d    = s_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    ob_we  = 1'b0;
    last_wr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_en) begin
          st_d   = ST_CALC;
          coef_d = '0;
          term_d = '0;
          s_d    = '0;
          acc_d  = '0;
        end
      end
      ST_CALC: begin
        term_d = term_q + 1'b1;
        if (y == 3'd7) begin
          s_d   = '0;
          acc_d = acc_q + outer;
        end else begin
          s_d = s_full;
        end
        if (term_q == AW'(N * N - 1)) st_d = ST_SCALE;
      end
      ST_SCALE: begin
        ob_we = 1'b1;
        acc_d = '0;
        if (coef_q == AW'(N * N - 1)) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          last_wr = 1'b1;
        end else begin
          st_d   = ST_CALC;
          coef_d = coef_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      coef_q <= '0;
      term_q <= '0;
      s_q    <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      coef_q <= coef_d;
      term_q <= term_d;
      s_q    <= s_d;
      acc_q  <= acc_d;
      done_q <= done_d;
    end
  end

  assign pix_addr = term_q;
  assign ob_addr  = coef_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/dct8_top.sv
module dct8_top
  import dct8_pkg::*;
#(
  parameter int PIX_WIDTH = PIX_W,
  parameter int OUT_WIDTH = OUT_W,
  parameter int Q_SHIFT   = QSHIFT,
  localparam int AW       = $clog2(N * N)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_valid,
  input  logic signed [PIX_WIDTH-1:0] push_data,
  input  logic                        start,
  input  logic                        pop_req,
  output logic                        busy,
  output logic                        done,
  output logic signed [OUT_WIDTH-1:0] pop_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       push_en, pop_en, start_en, ob_we, last_wr;
  logic [AW-1:0] wr_idx, rd_idx, pix_addr, ob_addr;
  logic signed [PIX_WIDTH-1:0] pix_data;
  logic signed [OUT_WIDTH-1:0] ob_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign push_en  = push_valid & ~busy;
  assign pop_en   = pop_req & ~busy;
  assign start_en = start & ~busy;

  dct8_in_buf #(.W(PIX_WIDTH), .DEPTH(N * N)) in_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(push_en), .wr_data(push_data),
    .rd_addr(pix_addr), .rd_data(pix_data), .wr_idx(wr_idx));

  dct8_engine #(.PW(PIX_WIDTH), .OW(OUT_WIDTH), .QSH(Q_SHIFT)) eng_i (
    .clk(clk), .rst_n(rst_int_n), .start_en(start_en), .pix_data(pix_data),
    .pix_addr(pix_addr), .ob_we(ob_we), .ob_addr(ob_addr), .ob_data(ob_data),
    .last_wr(last_wr), .busy(busy), .done(done));

  dct8_out_buf #(.W(OUT_WIDTH), .DEPTH(N * N)) out_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(ob_we), .wr_addr(ob_addr),
    .wr_data(ob_data), .pop_en(pop_en), .clr(last_wr),
    .rd_data(pop_data), .rd_idx(rd_idx));
endmodule

// File: rtl/dct8_chk.sv
module dct8_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             push_valid,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rd_idx
);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r1_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wr_idx));
  a_r1_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !busy) |=> (wr_idx == $past(wr_idx) + 1'b1));
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rd_idx) || done));
  a_r6_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_idx == '0));
endmodule

bind dct8_top dct8_chk #(.IDX_W(6)) chk_i (.*);

// File: tb/dct8_top_tb_top.sv
module dct8_top_tb_top;
  localparam int BUSY_CYC = 4160;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0, start = 1'b0, pop_req = 1'b0;
  logic signed [7:0] push_data = '0;
  logic busy, done;
  logic signed [15:0] pop_data;

  int checks = 0, errors = 0, cycles = 0;
  bit chk_en = 0;
  string tag = "R4/R5/R6";

  // behavioural reference state
  int m_in[64], m_pend[64], m_out[64];
  int m_wr = 0, m_rd = 0, m_cnt = 0;
  bit m_done = 0, m_valid = 0;

  always #5 clk = ~clk;

  dct8_top dut_i (.clk(clk), .rst_n(rst_n), .push_valid(push_valid),
    .push_data(push_data), .start(start), .pop_req(pop_req),
    .busy(busy), .done(done), .pop_data(pop_data));

  function automatic int cq(int p, int f);
    real a, m;
    int mi;
    a  = $cos(real'((2 * p + 1) * f) * PI / 16.0);
    m  = (a < 0.0 ? -a : a) * 32768.0;
    mi = $rtoi(m + 1.0e-9);
    return (a < 0.0) ? -mi : mi;
  endfunction

  function automatic int ref_coef(int u, int v);
    longint s = 0;
    real k, r;
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        s += longint'(m_in[x * 8 + y]) * cq(y, v) * cq(x, u);
    k = (u == 0 ? 23170.0 : 32768.0) * (v == 0 ? 23170.0 : 32768.0);
    r = real'(s) * k / (2.0 ** 68);
    return $rtoi($floor(r));
  endfunction

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // reference model advanced on every clock
  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_valid = 1; m_rd = 0;
          for (int i = 0; i < 64; i++) m_out[i] = m_pend[i];
        end
      end else begin
        if (push_valid) begin
          m_in[m_wr] = int'(push_data);
          m_wr = (m_wr + 1) % 64;
        end
        if (pop_req) m_rd = (m_rd + 1) % 64;
        if (start) begin
          for (int i = 0; i < 64; i++) m_pend[i] = ref_coef(i / 8, i % 8);
          m_cnt = BUSY_CYC;
        end
      end
    end
  end

  // compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    cycles++;
    if (chk_en) begin
      check("R2", busy == (m_cnt > 0), int'(busy), int'(m_cnt > 0));
      check("R3", done == m_done, int'(done), int'(m_done));
      if (m_valid && !busy) begin
        int d = int'(pop_data) - m_out[m_rd];
        check(tag, (d >= -1) && (d <= 1), int'(pop_data), m_out[m_rd]);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int pix(int mode, int i);
    int x = i / 8, y = i % 8;
    case (mode)
      0: return 100;
      1: return ((x + y) % 2 == 1) ? -128 : 127;
      2: return x * 16 - y * 9 - 20;
      default: return ((i * 97 + mode * 31) % 256) - 128;
    endcase
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      push_valid = 0; start = 0; pop_req = 0;
    end
  endtask

  task automatic push_one(int val, bit with_start);
    @(negedge clk);
    push_valid = 1; push_data = 8'(val); start = with_start; pop_req = 0;
  endtask

  task automatic load(int mode, int count, bit start_last);
    for (int i = 0; i < count; i++)
      push_one(pix(mode, i), start_last && (i == count - 1));
    idle(1);
  endtask

  task automatic go();
    @(negedge clk);
    start = 1;
    idle(1);
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 5000) begin
      @(negedge clk);
      g++;
    end
    idle(1);
  endtask

  task automatic pop_n(int n);
    repeat (n) begin
      @(negedge clk);
      pop_req = 1;
    end
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    check("reset", !busy && !done, int'(busy) + int'(done), 0);
    chk_en = 1;

    // constant tile: DC only
    tag = "R4/R5/R6 const";
    load(0, 64, 0); go(); wait_done(); pop_n(64);

    // checkerboard at full range, with pushes, pops, starts during busy
    tag = "R1/R7/R2 busy-ignore";
    load(1, 64, 0); go();
    repeat (200) begin
      @(negedge clk);
      push_valid = 1; push_data = 8'sd55; pop_req = 1; start = 1;
    end
    idle(1);
    wait_done(); pop_n(64);

    // ramp, last push together with start
    tag = "R8 push+start";
    load(2, 64, 1); wait_done(); pop_n(64);

    // 70 pushes: index wraps, first six entries overwritten
    tag = "R1 wrap";
    load(3, 64, 0); load(4, 6, 0); go(); wait_done();

    // 70 pops: read index wraps
    tag = "R6 pop wrap";
    pop_n(70);

    // pseudo-random tile
    tag = "R4/R5 random";
    load(5, 64, 0); go(); wait_done(); pop_n(64);

    idle(2);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule